// File: doc/BRIEF.md
# Sweep-Tracking Calibrator Divider

This block turns a 5 MHz timing clock into the calibrator square wave. The output frequency follows the horizontal sweep speed, so the calibrator trace always shows five complete cycles across a 10-division screen. An output period is twice the time per division. The divide ratio is therefore N = 10 × (time per division) × 5 MHz / 5. N runs from 1 at 0.1 µs/div up to 1,000,000 at 100 ms/div.

The sweep setting arrives as a small code that steps through the 1-2-5 time-per-division sequence. Codes faster than the calibrated range hold the output at the reference frequency, where the reference clock is passed straight through. Codes slower than the range hold it at 5 Hz. Each time a new output period starts, the block also raises a one-cycle terminal-count strobe. A change of sweep code waits for the end of the current period, so the output never carries a runt pulse.

Top module: `sweep_cal_div`

## Requirements
- R1: While `rst` is high, `cal_out` and `cal_tc` are both low, including while `clk` is high.
- R2: The divide ratio N for code c is computed with s = c − LO_CODE (LO_CODE = 4 by default). For c ≤ LO_CODE, N = 1. Otherwise N = m × 10^(s/3), with m = 1, 2 or 5 when s mod 3 is 0, 1 or 2, and the division taken as an integer. The output period is N cycles of `clk`.
- R3: Codes at or above LO_CODE + 3 × DECADES (22 by default) saturate at N = 10^DECADES, which is 1,000,000, or 5 Hz.
- R4: When N = 1, `cal_out` follows `clk`: high while `clk` is high and low while it is low. `cal_tc` stays high for the whole time.
- R5: When N ≥ 2, `cal_out` is high for ceil(N/2) cycles and then low for floor(N/2) cycles. Only the odd ratio, N = 5, is unequal, at 3 high and 2 low.
- R6: When N ≥ 2, `cal_tc` is high for exactly one cycle per period. That cycle is the first high cycle of `cal_out`.
- R7: A new sweep code does not alter the period in progress. It takes effect at the start of the first output period that begins after the code has been registered.
- R8: The first output period starts on the first rising edge of `clk` after `rst` falls. It uses the ratio of the code that was present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 MHz timing reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_code | input | CODE_W | Sweep-speed index into 1-2-5 steps |
| cal_out | output | 1 | Calibrator square wave |
| cal_tc | output | 1 | Period-start strobe |

## Verification
The hardest situation to reach is a code change that lands in the middle of a long period. The test must show that the old high and low lengths still finish exactly and that the new ratio starts only at the next boundary. The stimulus sets a ratio of 100, locks onto a period start, and waits ten cycles. It then switches to a ratio of 2 and counts the remaining 39 high and 50 low cycles before checking the new 1/1 period. The bench builds the block with three decades, so a full pass over all 32 codes, covering both clamps and both transitions into and out of pass-through, fits into the run.

// File: rtl/cald_pkg.sv
package cald_pkg;

  typedef enum logic [1:0] {
    PH_LO   = 2'd0,
    PH_HI   = 2'd1,
    PH_PASS = 2'd2
  } cald_phase_e;

  // Divide ratio for a sweep index: 1-2-5 steps above lo_code, clamped both ends.
  function automatic longint unsigned cald_ratio(input int code, input int lo_code,
                                                 input int decades);
    int step;
    longint unsigned n;
    if (code <= lo_code) return 64'd1;
    step = code - lo_code;
    if (step > 3 * decades) step = 3 * decades;
    n = 64'd1;
    for (int d = 0; d < step / 3; d++) n = n * 64'd10;
    case (step % 3)
      1:       n = n * 64'd2;
      2:       n = n * 64'd5;
      default: n = n;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cald_ratio_rom.sv
module cald_ratio_rom #(
  parameter int CODE_W  = 5,
  parameter int LO_CODE = 4,
  parameter int DECADES = 6,
  parameter int CNT_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic              byp_o,
  output logic [CNT_W-1:0]  hi_o,
  output logic [CNT_W-1:0]  lo_o
);
  import cald_pkg::*;

  localparam int DEPTH   = 1 << CODE_W;
  localparam int WORD_W  = 2 * CNT_W + 1;
  localparam int HI_CODE = LO_CODE + 3 * DECADES;
  localparam longint unsigned MAX_N = cald_ratio(HI_CODE, LO_CODE, DECADES);

  logic [WORD_W-1:0] rom [DEPTH];
  logic [WORD_W-1:0] word_q;

  // Table computed at elaboration: {pass-through, high length, low length}.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam longint unsigned NG = cald_ratio(g, LO_CODE, DECADES);
    assign rom[g] = {(NG == 64'd1), CNT_W'((NG + 64'd1) / 64'd2), CNT_W'(NG / 64'd2)};
  end

  // Registered read, loaded also during reset so the first period is valid.
  always_ff @(posedge clk) word_q <= rom[code_i];

  assign byp_o = word_q[WORD_W-1];
  assign hi_o  = word_q[2*CNT_W-1:CNT_W];
  assign lo_o  = word_q[CNT_W-1:0];

  a_r3_slow_clamp: assert property (@(posedge clk) disable iff (rst)
    (int'(code_i) >= HI_CODE) |=> (longint'(hi_o) + longint'(lo_o) == longint'(MAX_N)));

  a_r4_fast_clamp: assert property (@(posedge clk) disable iff (rst)
    (int'(code_i) <= LO_CODE) |=> byp_o);

  a_r5_split: assert property (@(posedge clk) disable iff (rst)
    !byp_o |-> (hi_o == lo_o || hi_o == lo_o + CNT_W'(1)));

endmodule

// File: rtl/cald_phase_timer.sv
module cald_phase_timer #(
  parameter int CNT_W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  nx_byp,
  input  logic [CNT_W-1:0]      nx_hi,
  input  logic [CNT_W-1:0]      nx_lo,
  output cald_pkg::cald_phase_e ph_o,
  output logic                  tc_o
);
  import cald_pkg::*;

  cald_phase_e      ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lo_q;
  logic             tc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_LO;
      cnt_q <= CNT_W'(1);
      lo_q  <= CNT_W'(1);
      tc_q  <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      unique case (ph_q)
        PH_PASS: begin
          tc_q <= 1'b1;
          if (!nx_byp) begin
            ph_q  <= PH_HI;
            cnt_q <= nx_hi;
            lo_q  <= nx_lo;
          end
        end
        PH_HI: begin
          if (cnt_q == CNT_W'(1)) begin
            ph_q  <= PH_LO;
            cnt_q <= lo_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_LO: begin
          if (cnt_q == CNT_W'(1)) begin
            // Period boundary: the only point where a new ratio is adopted.
            tc_q <= 1'b1;
            if (nx_byp) begin
              ph_q <= PH_PASS;
            end else begin
              ph_q  <= PH_HI;
              cnt_q <= nx_hi;
              lo_q  <= nx_lo;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: ph_q <= PH_LO;
      endcase
    end
  end

  assign ph_o = ph_q;
  assign tc_o = tc_q;

  a_r6_single_tc: assert property (@(posedge clk) disable iff (rst)
    (tc_q && ph_q != PH_PASS) |=> !tc_q);

  a_r6_tc_on_rise: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HI && $past(ph_q) != PH_HI) |-> tc_q);

  a_r7_hold_in_phase: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_PASS && cnt_q != CNT_W'(1)) |=> (ph_q == $past(ph_q)));

  a_r5_cnt_live: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_PASS) |-> (cnt_q != '0));

endmodule

// File: rtl/sweep_cal_div.sv
module sweep_cal_div #(
  parameter int CODE_W  = 5,
  parameter int LO_CODE = 4,
  parameter int DECADES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sweep_code,
  output logic              cal_out,
  output logic              cal_tc
);
  import cald_pkg::*;

  localparam longint unsigned MAX_N = cald_ratio(LO_CODE + 3 * DECADES, LO_CODE, DECADES);
  localparam int CNT_W = $clog2(MAX_N + 64'd1);

  logic             nx_byp;
  logic [CNT_W-1:0] nx_hi;
  logic [CNT_W-1:0] nx_lo;
  cald_phase_e      ph;
  logic             tc;

  cald_ratio_rom #(
    .CODE_W (CODE_W),
    .LO_CODE(LO_CODE),
    .DECADES(DECADES),
    .CNT_W  (CNT_W)
  ) u_rom (
    .clk   (clk),
    .rst   (rst),
    .code_i(sweep_code),
    .byp_o (nx_byp),
    .hi_o  (nx_hi),
    .lo_o  (nx_lo)
  );

  cald_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .nx_byp(nx_byp),
    .nx_hi (nx_hi),
    .nx_lo (nx_lo),
    .ph_o  (ph),
    .tc_o  (tc)
  );

  // Divide-by-one cannot be registered: the reference itself is gated out.
  assign cal_out = (ph == PH_PASS) ? clk : (ph == PH_HI);
  assign cal_tc  = tc;

  a_r4_pass_strobe: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PASS) |-> cal_tc);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PASS) |-> $past(nx_byp));

endmodule

// File: tb/sim_sweep_cal_div.sv
module sim_sweep_cal_div;
  localparam int CW  = 5;
  localparam int LO  = 4;
  localparam int DEC = 3;
  localparam int HI  = LO + 3 * DEC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] code = CW'(7);
  logic          cal_out;
  logic          cal_tc;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  sweep_cal_div #(.CODE_W(CW), .LO_CODE(LO), .DECADES(DEC)) u0 (
    .clk(clk), .rst(rst), .sweep_code(code), .cal_out(cal_out), .cal_tc(cal_tc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #15;
  endtask

  function automatic int exp_n(input int c);
    int s;
    int n;
    if (c <= LO) return 1;
    s = c - LO;
    if (s >= 3 * DEC) s = 3 * DEC;
    n = (s % 3 == 0) ? 1 : ((s % 3 == 1) ? 2 : 5);
    for (int k = 0; k < s / 3; k++) n = n * 10;
    return n;
  endfunction

  task automatic wait_start();
    for (int k = 0; k < 5000; k++) begin
      step();
      if (cal_tc && cal_out) return;
    end
    check(1'b0, "R6", "period start not seen", 0, 1);
  endtask

  task automatic measure(input int c, input string req);
    int n, hi, lo, xtc;
    n = exp_n(c);
    wait_start();
    wait_start();
    hi = 1; lo = 0; xtc = 0;
    for (int k = 0; k < 5000; k++) begin
      step();
      if (!cal_out) break;
      hi++;
      if (cal_tc) xtc++;
    end
    for (int k = 0; k < 5000; k++) begin
      if (cal_out || cal_tc) break;
      lo++;
      step();
    end
    check(hi == (n + 1) / 2, req, $sformatf("code %0d high cycles (R5)", c), hi, (n + 1) / 2);
    check(lo == n / 2, req, $sformatf("code %0d low cycles (R5)", c), lo, n / 2);
    check(xtc == 0, "R6", $sformatf("code %0d extra strobes", c), xtc, 0);
    check(cal_tc && cal_out, "R6", $sformatf("code %0d strobe at next start", c),
          {cal_tc, cal_out}, 3);
  endtask

  task automatic check_pass(input int prev_n);
    repeat (2 * prev_n + 6) step();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #5;
      check(cal_out && cal_tc, "R4", "pass-through high half", {cal_out, cal_tc}, 3);
      @(negedge clk);
      #5;
      check(!cal_out && cal_tc, "R4", "pass-through low half", {cal_out, cal_tc}, 1);
    end
  endtask

  initial begin
    int prev, hi, lo;
    repeat (4) @(posedge clk);
    #5;
    check(!cal_out && !cal_tc, "R1", "reset with clk high", {cal_out, cal_tc}, 0);
    #10;
    check(!cal_out && !cal_tc, "R1", "reset with clk low", {cal_out, cal_tc}, 0);
    rst = 1'b0;
    step();
    check(cal_out && cal_tc, "R8", "first period start", {cal_out, cal_tc}, 3);
    measure(7, "R8");

    prev = exp_n(7);
    for (int c = 0; c < (1 << CW); c++) begin
      code = CW'(c);
      if (exp_n(c) == 1) check_pass(prev);
      else measure(c, (c >= HI) ? "R3" : "R2");
      prev = exp_n(c);
    end

    // R7: change code ten cycles into a 100-cycle period
    code = CW'(10);
    wait_start();
    wait_start();
    repeat (10) step();
    code = CW'(5);
    hi = 0; lo = 0;
    for (int k = 0; k < 5000; k++) begin
      step();
      if (!cal_out) break;
      hi++;
    end
    for (int k = 0; k < 5000; k++) begin
      if (cal_out || cal_tc) break;
      lo++;
      step();
    end
    check(hi == 39, "R7", "old high remainder", hi, 39);
    check(lo == 50, "R7", "old low length", lo, 50);
    step();
    check(!cal_out, "R7", "new ratio high length 1", cal_out, 0);
    step();
    check(cal_out && cal_tc, "R7", "new ratio period 2", {cal_out, cal_tc}, 3);

    code = CW'(0);
    check_pass(2);
    code = CW'(31);
    measure(31, "R3");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule